// File: doc/BRIEF.md
# Raster Vector Generator Step Engine

This block walks a pixel position across a nibble-addressed display memory to carry out one drawing command at a time: a pen move, a single dot, a straight vector, or a wipe of the whole memory. A host loads the start position, a direction code, a step count, a mode with a write operation, an 8-bit line pattern and a pattern multiplier through a small register port, then pulses `go`. The engine stays busy until the command completes.

Each step begins with a lookup in a registered direction table. The table address is built from the direction register, an externally computed error carry, the Y counter LSB and a feedback bit that the table produces itself. The table word sets the X and Y count enables, the count directions, and a write strobe that also decrements the step counter. The engine then reads the nibble at the new position and may write it back. The new value comes from a pattern logic function of the current pattern bit, the write operation, X[1:0] and the old nibble. The error accumulator that produces the carry lies outside the block.

Top module: `vg_engine`

## Requirements
- R1: After reset `busy`, `mem_rd` and `mem_we` are 0 and both position counters read 0.
- R2: With direction bit 3 clear, every step moves by the low 3 direction bits: 0 gives +X, 1 gives +X−Y, 2 gives −Y, 3 gives −X−Y, 4 gives −X, 5 gives −X+Y, 6 gives +Y, 7 gives +X+Y. Between two cycles of a command, each counter changes by at most one.
- R3: The X and Y counters are 12 bits wide and wrap modulo 4096, so 0 minus 1 reads 0xFFF. Both are output in full. The memory address is {Y[Y_AB-1:0], X[X_AB-1:0]}.
- R4: With direction bit 3 set, the first step after `go` holds the position and still counts and plots. This uses the feedback bit, which is 1 while idle and 0 after the first step. Later steps move as in R2.
- R5: With direction bit 3 set and an odd direction code, a step taken with `err_carry` = 0 moves only along X. With `err_carry` = 1 it moves along both axes.
- R6: Mode 0 (move) makes exactly `count` steps and writes nothing.
- R7: Mode 1 (dot) makes `count` steps and writes only on the step that brings the count to zero.
- R8: Mode 2 (vector) writes on every step. Each write follows a read of the same address in the cycle before.
- R9: A write changes only bit X[1:0] of the nibble. With p = pattern bit XOR op[2], op[1:0] = 0 sets the bit to p, 1 ORs it with p, 2 clears it where p is 1, and 3 XORs it with p.
- R10: The pattern bit index starts at 0 on `go`. A 4-bit counter is loaded with the multiplier on `go` and steps after every step. When it is at 15, the index advances by one (mod 8) and the counter reloads. This gives one advance every 16 − multiplier steps.
- R11: Mode 3 (erase) writes 0 to every address from 0 to the last, one per cycle and in ascending order, then ends. X and Y do not change.
- R12: Register writes and `go` are ignored while `busy`. A `go` with a zero count in a mode other than erase does nothing. Register map: 0 X, 1 Y, 2 direction[3:0], 3 count[7:0], 4 {op[4:2], mode[1:0]}, 5 pattern[7:0], 6 multiplier[3:0].
- R13: `mem_we` is asserted only while `busy`, and never in the same cycle as `mem_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Host register write strobe |
| reg_addr | input | 3 | Host register select |
| reg_wdata | input | CNT_W | Host register write data |
| go | input | 1 | Command start strobe |
| err_carry | input | 1 | Error carry from the external accumulator, sampled once per step |
| mem_rdata | input | 4 | Read nibble, valid the cycle after `mem_rd` |
| busy | output | 1 | Command in progress |
| x_pos | output | CNT_W | X counter |
| y_pos | output | CNT_W | Y counter |
| mem_addr | output | X_AB+Y_AB | Memory nibble address |
| mem_rd | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 4 | Memory write nibble |

## Verification
The bound checker watches four things on every cycle. Position moves are limited to one unit per cycle during a command. The position stays still while idle unless the host loads it. Read and write strobes never overlap, and writes occur only while busy. Every drawing write lands on the address read just before it, and the erase address climbs by one each cycle. Only the bench scenarios can show the rest: the exact step pattern of each direction code, the hold on the first step and the carry gating, the single dot write, the nibble values from the pattern logic and pattern advance, and that erase covers every word exactly once. The bench shows these by predicting each write into a scoreboard and comparing the final positions.

// File: rtl/vg_pkg.sv
package vg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOK, ST_MOVE, ST_RD, ST_WR, ST_ERASE
  } vg_state_e;

  typedef enum logic [1:0] {
    MD_MOVE = 2'd0, MD_DOT = 2'd1, MD_VEC = 2'd2, MD_ERASE = 2'd3
  } vg_mode_e;

  localparam logic [2:0] RA_X    = 3'd0;
  localparam logic [2:0] RA_Y    = 3'd1;
  localparam logic [2:0] RA_DIR  = 3'd2;
  localparam logic [2:0] RA_CNT  = 3'd3;
  localparam logic [2:0] RA_MODE = 3'd4;
  localparam logic [2:0] RA_PAT  = 3'd5;
  localparam logic [2:0] RA_PMUL = 3'd6;

  // Direction table word: bit5 feedback, bit4 write/decrement,
  // bit3 X down, bit2 Y down, bit1 X enable, bit0 Y enable.
  typedef struct packed {
    logic fb_next;
    logic wr;
    logic x_dn;
    logic y_dn;
    logic x_en;
    logic y_en;
  } dir_word_t;

  // Address: [7] tied low, [6] feedback, [5] Y lsb, [4] carry, [3:0] direction.
  function automatic dir_word_t dir_lookup(input logic [7:0] a);
    dir_word_t w;
    logic [2:0] d;
    logic ex, ey;
    d  = a[2:0];
    ex = (d != 3'd2) && (d != 3'd6);
    ey = (d != 3'd0) && (d != 3'd4);
    if (a[3]) begin
      if (a[6]) begin
        ex = 1'b0;
        ey = 1'b0;
      end else if (d[0] && !a[4]) begin
        ey = 1'b0;
      end
    end
    w.fb_next = 1'b0;
    w.wr      = ~a[7];
    w.x_dn    = (d == 3'd3) || (d == 3'd4) || (d == 3'd5);
    w.y_dn    = (d == 3'd1) || (d == 3'd2) || (d == 3'd3);
    w.x_en    = ex;
    w.y_en    = ey;
    if (a[7]) w = '0;
    return w;
  endfunction

  // Address: [9] pattern bit, [8:6] write op, [5:4] pixel select, [3:0] old nibble.
  function automatic logic [3:0] nib_logic(input logic [9:0] a);
    logic p, b, nb;
    logic [1:0] s;
    logic [3:0] r;
    p = a[9] ^ a[8];
    s = a[5:4];
    r = a[3:0];
    b = r[s];
    case (a[7:6])
      2'd0:    nb = p;
      2'd1:    nb = b | p;
      2'd2:    nb = b & ~p;
      default: nb = b ^ p;
    endcase
    r[s] = nb;
    return r;
  endfunction

endpackage

// File: rtl/vg_dir_table.sv
module vg_dir_table
  import vg_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      active,
  input  logic      look,
  input  logic      adv,
  input  logic [3:0] dir,
  input  logic      carry,
  input  logic      y0,
  output dir_word_t word
);

  logic fb;

  always_ff @(posedge clk) begin
    if (rst) begin
      fb   <= 1'b1;
      word <= '0;
    end else begin
      if (!active)  fb <= 1'b1;
      else if (adv) fb <= word.fb_next;
      if (look) word <= dir_lookup({1'b0, fb, y0, carry, dir});
    end
  end

endmodule

// File: rtl/vg_xy_counters.sv
module vg_xy_counters
  import vg_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_x,
  input  logic             ld_y,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             step,
  input  dir_word_t        word,
  output logic [CNT_W-1:0] x,
  output logic [CNT_W-1:0] y
);

  always_ff @(posedge clk) begin
    if (rst) begin
      x <= '0;
      y <= '0;
    end else begin
      if (ld_x)                    x <= ld_val;
      else if (step && word.x_en)  x <= word.x_dn ? x - 1'b1 : x + 1'b1;
      if (ld_y)                    y <= ld_val;
      else if (step && word.y_en)  y <= word.y_dn ? y - 1'b1 : y + 1'b1;
    end
  end

endmodule

// File: rtl/vg_pattern.sv
module vg_pattern #(
  parameter int PAT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             adv,
  input  logic [PAT_W-1:0] pat,
  input  logic [3:0]       pmul,
  output logic             pat_bit
);

  localparam int IW = (PAT_W > 1) ? $clog2(PAT_W) : 1;

  logic [IW-1:0] idx;
  logic [3:0]    mcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx  <= '0;
      mcnt <= '0;
    end else if (start) begin
      idx  <= '0;
      mcnt <= pmul;
    end else if (adv) begin
      if (mcnt == 4'hF) begin
        idx  <= (idx == IW'(PAT_W - 1)) ? '0 : idx + 1'b1;
        mcnt <= pmul;
      end else begin
        mcnt <= mcnt + 1'b1;
      end
    end
  end

  assign pat_bit = pat[idx];

endmodule

// File: rtl/vg_engine.sv
module vg_engine
  import vg_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int X_AB  = 9,
  parameter int Y_AB  = 10,
  parameter int DC_W  = 8,
  parameter int PAT_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_we,
  input  logic [2:0]           reg_addr,
  input  logic [CNT_W-1:0]     reg_wdata,
  input  logic                 go,
  input  logic                 err_carry,
  input  logic [3:0]           mem_rdata,
  output logic                 busy,
  output logic [CNT_W-1:0]     x_pos,
  output logic [CNT_W-1:0]     y_pos,
  output logic [X_AB+Y_AB-1:0] mem_addr,
  output logic                 mem_rd,
  output logic                 mem_we,
  output logic [3:0]           mem_wdata
);

  localparam int AW = X_AB + Y_AB;

  vg_state_e        st;
  logic [3:0]       dir_q;
  logic [DC_W-1:0]  cnt_q, dc;
  vg_mode_e         mode_q;
  logic [2:0]       wop_q;
  logic [PAT_W-1:0] pat_q;
  logic [3:0]       pmul_q;
  logic [AW-1:0]    er_addr;
  logic             do_wr, last;
  logic             host_wr, start, step_end, active, erasing, pat_bit;
  dir_word_t        word;

  assign host_wr  = reg_we && (st == ST_IDLE);
  assign start    = (st == ST_IDLE) && go && (mode_q != MD_ERASE) && (cnt_q != '0);
  assign step_end = ((st == ST_RD) && !do_wr) || (st == ST_WR);
  assign active   = (st != ST_IDLE) && (st != ST_ERASE);
  assign erasing  = (st == ST_ERASE);

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '0;
      cnt_q  <= '0;
      mode_q <= MD_MOVE;
      wop_q  <= '0;
      pat_q  <= '0;
      pmul_q <= '0;
    end else if (host_wr) begin
      case (reg_addr)
        RA_DIR:  dir_q  <= reg_wdata[3:0];
        RA_CNT:  cnt_q  <= reg_wdata[DC_W-1:0];
        RA_MODE: begin
          mode_q <= vg_mode_e'(reg_wdata[1:0]);
          wop_q  <= reg_wdata[4:2];
        end
        RA_PAT:  pat_q  <= reg_wdata[PAT_W-1:0];
        RA_PMUL: pmul_q <= reg_wdata[3:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      dc      <= '0;
      do_wr   <= 1'b0;
      last    <= 1'b0;
      er_addr <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (go && mode_q == MD_ERASE) begin
            st      <= ST_ERASE;
            er_addr <= '0;
          end else if (start) begin
            st <= ST_LOOK;
            dc <= cnt_q;
          end
        end
        ST_LOOK: st <= ST_MOVE;
        ST_MOVE: begin
          if (word.wr) dc <= dc - 1'b1;
          do_wr <= word.wr && ((mode_q == MD_VEC) ||
                               ((mode_q == MD_DOT) && (dc == DC_W'(1))));
          last  <= word.wr && (dc == DC_W'(1));
          st    <= ST_RD;
        end
        ST_RD: begin
          if (do_wr)     st <= ST_WR;
          else if (last) st <= ST_IDLE;
          else           st <= ST_LOOK;
        end
        ST_WR:   st <= last ? ST_IDLE : ST_LOOK;
        ST_ERASE: begin
          er_addr <= er_addr + 1'b1;
          if (&er_addr) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  vg_dir_table u_dir (
    .clk    (clk),
    .rst    (rst),
    .active (active),
    .look   (st == ST_LOOK),
    .adv    (st == ST_MOVE),
    .dir    (dir_q),
    .carry  (err_carry),
    .y0     (y_pos[0]),
    .word   (word)
  );

  vg_xy_counters #(.CNT_W(CNT_W)) u_xy (
    .clk    (clk),
    .rst    (rst),
    .ld_x   (host_wr && reg_addr == RA_X),
    .ld_y   (host_wr && reg_addr == RA_Y),
    .ld_val (reg_wdata),
    .step   (st == ST_MOVE),
    .word   (word),
    .x      (x_pos),
    .y      (y_pos)
  );

  vg_pattern #(.PAT_W(PAT_W)) u_pat (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .adv     (step_end),
    .pat     (pat_q),
    .pmul    (pmul_q),
    .pat_bit (pat_bit)
  );

  assign busy      = (st != ST_IDLE);
  assign mem_addr  = erasing ? er_addr : {y_pos[Y_AB-1:0], x_pos[X_AB-1:0]};
  assign mem_rd    = (st == ST_RD);
  assign mem_we    = (st == ST_WR) || erasing;
  assign mem_wdata = erasing ? 4'h0 : nib_logic({pat_bit, wop_q, x_pos[1:0], mem_rdata});

endmodule

// File: rtl/vg_engine_chk.sv
module vg_engine_chk #(
  parameter int CNT_W = 12,
  parameter int AW    = 19
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             reg_we,
  input logic             mem_rd,
  input logic             mem_we,
  input logic             erasing,
  input logic [AW-1:0]    mem_addr,
  input logic [CNT_W-1:0] x_pos,
  input logic [CNT_W-1:0] y_pos
);

  a_r13_rd_we_excl: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_we));

  a_r13_we_only_busy: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);

  a_r8_rmw_same_addr: assert property (@(posedge clk) disable iff (rst)
    (mem_we && !erasing) |-> ($past(mem_rd) && mem_addr == $past(mem_addr)));

  a_r11_sweep_up: assert property (@(posedge clk) disable iff (rst)
    (erasing && $past(erasing)) |-> (mem_addr == $past(mem_addr) + AW'(1)));

  a_r11_xy_frozen: assert property (@(posedge clk) disable iff (rst)
    erasing |=> ($stable(x_pos) && $stable(y_pos)));

  a_r2_unit_step_x: assert property (@(posedge clk) disable iff (rst)
    busy |=> (x_pos == $past(x_pos) || x_pos == $past(x_pos) + CNT_W'(1) ||
              x_pos == $past(x_pos) - CNT_W'(1)));

  a_r2_unit_step_y: assert property (@(posedge clk) disable iff (rst)
    busy |=> (y_pos == $past(y_pos) || y_pos == $past(y_pos) + CNT_W'(1) ||
              y_pos == $past(y_pos) - CNT_W'(1)));

  a_r12_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!busy && !reg_we && !$past(rst)) |=> ($stable(x_pos) && $stable(y_pos)));

endmodule

bind vg_engine vg_engine_chk #(.CNT_W(CNT_W), .AW(AW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .reg_we   (reg_we),
  .mem_rd   (mem_rd),
  .mem_we   (mem_we),
  .erasing  (erasing),
  .mem_addr (mem_addr),
  .x_pos    (x_pos),
  .y_pos    (y_pos)
);

// File: tb/vg_engine_tb.sv
`timescale 1ns/1ps
module vg_engine_tb;

  localparam int XA = 4;
  localparam int YA = 3;
  localparam int AW = XA + YA;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_we = 1'b0, go = 1'b0, err_carry = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [11:0] reg_wdata = '0;
  logic [3:0]  mem_rdata, mem_wdata;
  logic        busy, mem_rd, mem_we;
  logic [11:0] x_pos, y_pos;
  logic [AW-1:0] mem_addr;

  logic [3:0] mem [DEPTH];
  int refmem [DEPTH];
  int exp_q [$];
  int checks = 0, fails = 0, nwr = 0;
  int rx = 0, ry = 0;

  always #2 clk = ~clk;

  vg_engine #(.CNT_W(12), .X_AB(XA), .Y_AB(YA), .DC_W(8), .PAT_W(8)) u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .go(go), .err_carry(err_carry), .mem_rdata(mem_rdata), .busy(busy),
    .x_pos(x_pos), .y_pos(y_pos), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_we(mem_we), .mem_wdata(mem_wdata)
  );

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr];
    if (mem_we) mem[mem_addr] <= mem_wdata;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor: each write is popped against the predicted item
  always @(negedge clk) begin
    if (!rst && mem_we) begin
      nwr++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6", "unexpected write", int'(mem_addr) * 16 + int'(mem_wdata), -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        chk(int'(mem_addr) * 16 + int'(mem_wdata) == e, "R8", "write addr*16+data",
            int'(mem_addr) * 16 + int'(mem_wdata), e);
      end
    end
  end

  task automatic wr_reg(input int a, input int v);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = 12'(v);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic pulse_go();
    @(negedge clk); go = 1'b1;
    @(negedge clk); go = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic set_pos(input int x, input int y);
    wr_reg(0, x); wr_reg(1, y);
    rx = x; ry = y;
  endtask

  // driver: predict the command from the requirements, push writes, then run it
  task automatic run_cmd(input int dir, input int cnt, input int mode, input int wop,
                         input int pat, input int pmul, input bit cy, input string req);
    int x, y, dc, pidx, pm, w0;
    bit fb;
    x = rx; y = ry; dc = cnt; pidx = 0; pm = pmul; fb = 1'b1; w0 = nwr;
    wr_reg(2, dir); wr_reg(3, cnt); wr_reg(4, (wop << 2) | mode);
    wr_reg(5, pat); wr_reg(6, pmul);
    err_carry = cy;
    if (mode == 3) begin
      for (int a = 0; a < DEPTH; a++) begin
        refmem[a] = 0;
        exp_q.push_back(a * 16);
      end
    end else begin
      while (dc > 0) begin
        int dx, dy;
        case (dir & 7)
          0: begin dx =  1; dy =  0; end
          1: begin dx =  1; dy = -1; end
          2: begin dx =  0; dy = -1; end
          3: begin dx = -1; dy = -1; end
          4: begin dx = -1; dy =  0; end
          5: begin dx = -1; dy =  1; end
          6: begin dx =  0; dy =  1; end
          default: begin dx = 1; dy = 1; end
        endcase
        if ((dir & 8) != 0) begin
          if (fb) begin dx = 0; dy = 0; end
          else if ((dir & 1) != 0 && !cy) dy = 0;
        end
        fb = 1'b0;
        x = (x + dx) & 12'hFFF;
        y = (y + dy) & 12'hFFF;
        dc--;
        if (mode == 2 || (mode == 1 && dc == 0)) begin
          int a, old, s, p, b, nb, nv;
          a   = ((y & ((1 << YA) - 1)) << XA) | (x & ((1 << XA) - 1));
          old = refmem[a];
          s   = x & 3;
          p   = ((pat >> pidx) & 1) ^ ((wop >> 2) & 1);
          b   = (old >> s) & 1;
          case (wop & 3)
            0: nb = p;
            1: nb = b | p;
            2: nb = b & (p ^ 1);
            default: nb = b ^ p;
          endcase
          nv = (old & ~(1 << s) & 15) | (nb << s);
          refmem[a] = nv;
          exp_q.push_back(a * 16 + nv);
        end
        if (pm == 15) begin pidx = (pidx + 1) % 8; pm = pmul; end
        else pm++;
      end
    end
    pulse_go();
    chk(busy == 1'b1, req, "busy after go", int'(busy), 1);
    wait_idle();
    @(negedge clk);
    if (mode != 3) begin rx = x; ry = y; end
    chk(int'(x_pos) == rx, req, "final x", int'(x_pos), rx);
    chk(int'(y_pos) == ry, req, "final y", int'(y_pos), ry);
    chk(exp_q.size() == 0, req, "writes still pending", exp_q.size(), 0);
    if (mode == 0) chk(nwr == w0, "R6", "write count in move", nwr - w0, 0);
    if (mode == 1) chk(nwr - w0 == 1, "R7", "write count in dot", nwr - w0, 1);
    if (mode == 3) chk(nwr - w0 == DEPTH, "R11", "erase write count", nwr - w0, DEPTH);
    exp_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", checks + 1, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i]    = 4'((i * 7 + 3) & 15);
      refmem[i] = (i * 7 + 3) & 15;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1", "busy", int'(busy), 0);
    chk(x_pos == 12'd0 && y_pos == 12'd0, "R1", "x/y", int'({x_pos, y_pos}), 0);
    chk(!mem_rd && !mem_we, "R1", "mem strobes", int'({mem_rd, mem_we}), 0);

    // R2 every direction code in move mode
    for (int d = 0; d < 8; d++) begin
      set_pos(100, 100);
      run_cmd(d, 3, 0, 0, 0, 0, 1'b0, "R2");
    end

    // R3 underflow wraps to 0xFFF on both counters
    set_pos(0, 0);
    run_cmd(3, 1, 0, 0, 0, 0, 1'b0, "R3");
    chk(x_pos == 12'hFFF && y_pos == 12'hFFF, "R3", "wrap", int'(x_pos), 12'hFFF);

    // R8 R9 R10 vectors with several write ops and pattern rates
    set_pos(0, 2);
    run_cmd(0, 6, 2, 0, 8'b0011_0101, 15, 1'b0, "R9");
    set_pos(3, 5);
    run_cmd(7, 5, 2, 1, 8'b1001_0110, 14, 1'b0, "R10");
    set_pos(9, 4);
    run_cmd(4, 7, 2, 3, 8'b1110_0001, 13, 1'b0, "R8");
    set_pos(1, 1);
    run_cmd(6, 5, 2, 6, 8'b0101_1100, 15, 1'b0, "R9");
    set_pos(5, 6);
    run_cmd(2, 4, 2, 2, 8'hFF, 0, 1'b0, "R9");

    // R7 dot
    set_pos(2, 0);
    run_cmd(6, 4, 1, 0, 8'h01, 15, 1'b0, "R7");

    // R4 first step holds the origin
    set_pos(20, 20);
    run_cmd(8, 3, 0, 0, 0, 0, 1'b0, "R4");
    set_pos(4, 3);
    run_cmd(8, 3, 2, 3, 8'hFF, 15, 1'b0, "R4");

    // R5 carry gating on diagonals
    set_pos(50, 50);
    run_cmd(9, 4, 0, 0, 0, 0, 1'b0, "R5");
    set_pos(50, 50);
    run_cmd(13, 4, 0, 0, 0, 0, 1'b1, "R5");

    // R12 register writes and go while busy are ignored
    set_pos(10, 1);
    wr_reg(2, 0); wr_reg(3, 5); wr_reg(4, 0);
    pulse_go();
    wr_reg(0, 700);
    wr_reg(3, 99);
    pulse_go();
    wait_idle();
    @(negedge clk);
    chk(x_pos == 12'd15, "R12", "x after ignored load", int'(x_pos), 15);
    rx = 15;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R12", "second go ignored", int'(busy), 0);
    // count register kept 5: a move of 5 steps ends at 20
    run_cmd(0, 5, 0, 0, 0, 0, 1'b0, "R12");
    // zero count go does nothing
    wr_reg(3, 0);
    pulse_go();
    chk(busy == 1'b0, "R12", "zero count busy", int'(busy), 0);
    repeat (2) @(negedge clk);
    chk(int'(x_pos) == rx, "R12", "zero count x", int'(x_pos), rx);

    // R11 erase, then R13 is covered by the checker throughout
    run_cmd(0, 0, 3, 0, 0, 0, 1'b0, "R11");
    chk(int'(x_pos) == rx && int'(y_pos) == ry, "R11", "x/y unchanged", int'(x_pos), rx);
    chk(mem[DEPTH-1] == 4'h0 && mem[0] == 4'h0, "R11", "memory cleared", int'(mem[DEPTH-1]), 0);
    chk(!mem_we, "R13", "no write when idle", int'(mem_we), 0);

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule